// File: doc/BRIEF.md
# Cycle Counter with Compare Interrupt

This block keeps a free-running cycle counter next to a compare register, both 32 bits wide by default, and raises the timer interrupt request for a processor's system-control coprocessor. The counter goes up by one on every cycle in which the advance input is high. It does not track wall time. When a step of the counter reaches or passes the compare value, the block sets a sticky pending flag. The flag is presented both as a single interrupt line and as one bit of a pending-interrupt vector that the coprocessor's cause register picks up directly.

Software reaches the two registers through a write port (select, data, strobe) and a combinational read port (select, data). Any write to either register acknowledges the timer interrupt. The match test is a signed-difference window, so it keeps working across counter wraparound. A write that moves the counter past the compare value never fires the interrupt.

The interrupt logic is a two-state machine. In `IRQ_IDLE` no interrupt is pending. The transition `ARM` (an un-written step crosses the compare value) leads to `IRQ_PENDING`. From `IRQ_PENDING`, the transition `ACK` (a write to either register) returns to `IRQ_IDLE`. Reset forces `IRQ_IDLE` from either state.

Top module: `cyc_timer_irq`

## Requirements
- R1: After reset the counter and compare registers both read 0, the interrupt line is low and the pending vector is all zeros.
- R2: With no write strobe, the counter rises by exactly one (modulo 2^32) at each clock edge where the advance input is high. It holds its value when the advance input is low.
- R3: The interrupt is set at the clock edge of an un-written counter step when two conditions hold. The signed 32-bit value (compare minus old count) must be strictly positive. The signed value (compare minus new count) must be zero or negative. The line is high in the same cycle that the counter first shows the compare value, including when compare sits just past the wrap from 0xFFFFFFFF to 0.
- R4: Once set, the interrupt stays high while the counter moves on past the compare value, as long as no write occurs.
- R5: A write strobe with select 0 loads the counter. A write strobe with select 1 loads the compare register. Either write clears the interrupt at that edge. During a counter write the advance input is ignored. During a compare write the counter still advances.
- R6: When a write and a crossing counter step fall in the same cycle, the write wins and the interrupt is low afterwards.
- R7: The pending vector has 8 bits. Bit 7 equals the interrupt line and every other bit is 0.
- R8: The read port returns the counter when its select is 0 and the compare register when its select is 1, with no clock delay.
- R9: A counter write that lands on or jumps past the compare value does not set the interrupt.
- R10: Every bit of both registers can be written and read back, for example the values 0xA5A55A5A and 0x5A5AA5A5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Advance enable: the counter steps by one at this edge |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write select: 0 counter, 1 compare |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read select: 0 counter, 1 compare |
| rd_data_o | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Timer interrupt pending level |
| cause_ip_o | output | 8 | Pending-interrupt vector, the timer on bit 7 |

## Verification
A corrupted counter shows up on the read port in the very next cycle, because the reference model tracks the counter value on every clock. A wrong compare register or a wrong window test stays hidden until the counter approaches the compare value. At that point the interrupt either fails to rise in the cycle the counter first equals compare, or it rises early. A stuck state machine shows up as a pending bit that survives a write, or that drops while the counter runs past the match. Each such case differs from the model in the first cycle after the edge that caused it.

// File: rtl/cti_pkg.sv
package cti_pkg;

    typedef enum logic {
        SEL_COUNT   = 1'b0,
        SEL_COMPARE = 1'b1
    } reg_sel_e;

    typedef enum logic [1:0] {
        IRQ_IDLE    = 2'b01,
        IRQ_PENDING = 2'b10
    } irq_state_e;

endpackage

// File: rtl/cti_count_reg.sv
module cti_count_reg
    import cti_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic load_cnt;

    always_comb begin
        load_cnt = wr_en && (wr_sel == SEL_COUNT);
        if (load_cnt) begin
            cnt_d = wr_data;
        end else if (adv) begin
            cnt_d = cnt_q + ONE;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/cti_compare_reg.sv
module cti_compare_reg
    import cti_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cmp_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (wr_en && (wr_sel == SEL_COMPARE)) begin
            cmp_q <= wr_data;
        end
    end

endmodule

// File: rtl/cti_cross_detect.sv
module cti_cross_detect #(
    parameter int CNT_W = 32
) (
    input  logic             step_ok,
    input  logic [CNT_W-1:0] cnt_old,
    input  logic [CNT_W-1:0] cnt_new,
    input  logic [CNT_W-1:0] cmp,
    output logic             crossed
);

    localparam int MSB = CNT_W - 1;

    logic [CNT_W-1:0] gap_before;
    logic [CNT_W-1:0] gap_after;
    logic             before_ahead;
    logic             after_reached;

    always_comb begin
        gap_before    = cmp - cnt_old;
        gap_after     = cmp - cnt_new;
        before_ahead  = !gap_before[MSB] && (gap_before != '0);
        after_reached = gap_after[MSB] || (gap_after == '0);
        crossed       = step_ok && before_ahead && after_reached;
    end

endmodule

// File: rtl/cti_irq_fsm.sv
module cti_irq_fsm
    import cti_pkg::*;
#(
    parameter int NUM_IP  = 8,
    parameter int IRQ_LVL = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              ack,
    output logic              irq,
    output logic [NUM_IP-1:0] cause_ip
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (arm && !ack) begin
                    state_d = IRQ_PENDING;
                end
            end
            IRQ_PENDING: begin
                if (ack) begin
                    state_d = IRQ_IDLE;
                end
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq = (state_q == IRQ_PENDING);
    end

    for (genvar gi = 0; gi < NUM_IP; gi++) begin : g_ip
        if (gi == IRQ_LVL) begin : g_timer
            assign cause_ip[gi] = irq;
        end else begin : g_other
            assign cause_ip[gi] = 1'b0;
        end
    end

endmodule

// File: rtl/cyc_timer_irq.sv
module cyc_timer_irq
    import cti_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_IP  = 8,
    parameter int IRQ_LVL = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic              rd_sel_i,
    output logic [CNT_W-1:0]  rd_data_o,
    output logic              irq_o,
    output logic [NUM_IP-1:0] cause_ip_o
);

    reg_sel_e         wsel;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cmp_q;
    logic             crossed;

    assign wsel = reg_sel_e'(wr_sel_i);

    cti_count_reg #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv_i),
        .wr_en   (wr_en_i),
        .wr_sel  (wsel),
        .wr_data (wr_data_i),
        .cnt_q   (cnt_q),
        .cnt_d   (cnt_d)
    );

    cti_compare_reg #(.CNT_W(CNT_W)) u_compare (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_sel  (wsel),
        .wr_data (wr_data_i),
        .cmp_q   (cmp_q)
    );

    cti_cross_detect #(.CNT_W(CNT_W)) u_cross (
        .step_ok (adv_i && !wr_en_i),
        .cnt_old (cnt_q),
        .cnt_new (cnt_d),
        .cmp     (cmp_q),
        .crossed (crossed)
    );

    cti_irq_fsm #(.NUM_IP(NUM_IP), .IRQ_LVL(IRQ_LVL)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (crossed),
        .ack      (wr_en_i),
        .irq      (irq_o),
        .cause_ip (cause_ip_o)
    );

    always_comb begin
        rd_data_o = (reg_sel_e'(rd_sel_i) == SEL_COMPARE) ? cmp_q : cnt_q;
    end

endmodule

// File: rtl/cyc_timer_irq_chk.sv
module cyc_timer_irq_chk #(
    parameter int CNT_W   = 32,
    parameter int NUM_IP  = 8,
    parameter int IRQ_LVL = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adv_i,
    input logic              wr_en_i,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  cmp_q,
    input logic              irq_o,
    input logic [NUM_IP-1:0] cause_ip_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R1: reset leaves zeros and no interrupt
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0 && cmp_q == '0 && !irq_o));

    // R2: stepping and holding
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && adv_i) |=> (cnt_q == $past(cnt_q) + ONE));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !adv_i) |=> $stable(cnt_q));

    // R3: landing on compare raises the interrupt
    assert_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && adv_i && (cnt_q + ONE == cmp_q)) |=> irq_o);

    // R4: pending level is sticky without writes
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !wr_en_i) |=> irq_o);

    // R5 and R6: any write acknowledges
    assert_write_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> !irq_o);

    // R7: only the timer bit of the pending vector may be set
    assert_cause_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_ip_o) && (cause_ip_o[IRQ_LVL] == irq_o));

endmodule

bind cyc_timer_irq cyc_timer_irq_chk #(
    .CNT_W   (CNT_W),
    .NUM_IP  (NUM_IP),
    .IRQ_LVL (IRQ_LVL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (adv_i),
    .wr_en_i    (wr_en_i),
    .cnt_q      (cnt_q),
    .cmp_q      (cmp_q),
    .irq_o      (irq_o),
    .cause_ip_o (cause_ip_o)
);

// File: tb/test_cyc_timer_irq.sv
`timescale 1ns/100ps
module test_cyc_timer_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        wr_sel_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        rd_sel_i = 1'b0;
    logic [31:0] rd_data_o;
    logic        irq_o;
    logic [7:0]  cause_ip_o;

    always #2 clk = ~clk;

    cyc_timer_irq i_cyc_timer_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv_i),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .rd_sel_i   (rd_sel_i),
        .rd_data_o  (rd_data_o),
        .irq_o      (irq_o),
        .cause_ip_o (cause_ip_o)
    );

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;
    string       phase = "R1";

    bit [31:0] m_cnt = 0;
    bit [31:0] m_cmp = 0;
    bit        m_irq = 0;

    task automatic cmp_val(string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", phase, what, act, exp);
        end
    endtask

    // sampled at the falling edge, away from the active edge (R8 read mux, R7 vector)
    task automatic check_all();
        bit [7:0] exp_ip;
        exp_ip = 8'(m_irq) << 7;
        rd_sel_i = 1'b0;
        #0.5;
        cmp_val("count", rd_data_o, m_cnt);
        rd_sel_i = 1'b1;
        #0.5;
        cmp_val("compare", rd_data_o, m_cmp);
        cmp_val("irq", 32'(irq_o), 32'(m_irq));
        cmp_val("cause_ip", 32'(cause_ip_o), 32'(exp_ip));
    endtask

    task automatic model_edge(bit adv, bit wr, bit sel, bit [31:0] data);
        if (wr) begin
            m_irq = 1'b0;
            if (!sel) begin
                m_cnt = data;
            end else begin
                m_cmp = data;
                if (adv) m_cnt = m_cnt + 1;
            end
        end else if (adv) begin
            int d_old;
            int d_new;
            d_old = int'(m_cmp - m_cnt);
            d_new = int'(m_cmp - (m_cnt + 32'd1));
            if (d_old > 0 && d_new <= 0) m_irq = 1'b1;
            m_cnt = m_cnt + 1;
        end
    endtask

    task automatic step(bit adv, bit wr, bit sel, bit [31:0] data);
        adv_i     = adv;
        wr_en_i   = wr;
        wr_sel_i  = sel;
        wr_data_i = data;
        @(posedge clk);
        model_edge(adv, wr, sel, data);
        @(negedge clk);
        adv_i   = 1'b0;
        wr_en_i = 1'b0;
        check_all();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        bit [31:0] lfsr;
        repeat (3) @(negedge clk);
        phase = "R1";
        check_all();
        rst_n = 1'b1;
        @(negedge clk);
        check_all();

        phase = "R2";
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
        for (int i = 0; i < 2; i++) step(0, 0, 0, 0);

        phase = "R10";
        step(0, 1, 1, 32'hA5A5_5A5A);
        step(0, 1, 0, 32'h5A5A_A5A5);
        step(0, 1, 1, 32'h5A5A_A5A5);
        step(0, 1, 0, 32'hA5A5_5A5A);

        phase = "R3";
        step(0, 1, 0, 32'd100);
        step(0, 1, 1, 32'd103);
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0);

        phase = "R4";
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
        step(0, 0, 0, 0);

        phase = "R5";
        step(1, 1, 1, 32'd103);
        step(0, 1, 0, 32'd102);
        step(1, 0, 0, 0);
        step(0, 1, 0, 32'd50);
        step(1, 0, 0, 0);

        phase = "R6";
        step(0, 1, 0, 32'd200);
        step(0, 1, 1, 32'd201);
        step(1, 1, 1, 32'd201);
        step(1, 0, 0, 0);

        phase = "R9";
        step(0, 1, 0, 32'd300);
        step(0, 1, 1, 32'd301);
        step(0, 1, 0, 32'd301);
        step(0, 1, 0, 32'd400);
        step(1, 0, 0, 0);

        phase = "R3";
        step(0, 1, 0, 32'hFFFF_FFFE);
        step(0, 1, 1, 32'h0000_0001);
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
        step(0, 1, 0, 32'hFFFF_FFFF);
        step(0, 1, 1, 32'h0000_0000);
        for (int i = 0; i < 2; i++) step(1, 0, 0, 0);

        phase = "R7";
        lfsr = 32'h1234_5679;
        for (int i = 0; i < 400; i++) begin
            bit w;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            w = (lfsr[4:0] == 5'd0);
            if (w && !lfsr[5]) begin
                step(lfsr[6], 1, 0, m_cmp - 32'(lfsr[9:7]) - 32'd1);
            end else if (w) begin
                step(lfsr[6], 1, 1, m_cnt + 32'(lfsr[9:7]) + 32'd1);
            end else begin
                step(lfsr[10] | lfsr[11], 0, 0, 0);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule